// File: doc/BRIEF.md
# Self-Seeding PRBS Error Checker

This block sits behind a serial receiver and deserializer. It takes one 40-bit parallel word per clock and compares it against one of three pseudo-random bit sequences. The sequences are 7-bit, 23-bit and 31-bit maximal-length sequences. The checker first derives its expected pattern from the received bits themselves, so it needs no training pattern and no word-boundary alignment. Any bit rotation of the serial stream inside the word is accepted.

After a programmable number of consecutive clean words, the checker declares lock and runs its sequence engine on internal state alone. From then on, corrupted received bits show up only at their own positions and cannot disturb the expected pattern. For every word it reports three things:

- a lock flag;
- the XOR of the received and expected words;
- the number of differing bits in that word.

Lock is dropped on a resynchronize request or when errored words pile up inside an observation window.

A companion 40-bit generator, built on the same unrolled sequence step, drives the transmit side of a link under test.

Top module: `prbs_checker`

## Requirements
- R1: Mode 0 selects x^7+x^6+1, mode 1 selects x^23+x^18+1, and mode 2 or 3 selects x^31+x^28+1. Serial bit n of a stream equals bit n-L XOR bit n-T, with (L,T) = (7,6), (23,18) or (31,28). Word bit 0 is the earliest in time.
- R2: The generator resets its 31-bit history to all ones and holds `gen_word_o` at all ones while reset is low. From the first clock edge after reset, it emits the next 40 sequence bits on each edge, so word k holds sequence bits 40k to 40k+39.
- R3: While reset is held low, `lock_o` is 0, `err_mask_o` is 0 and `err_cnt_o` is 0.
- R4: The word sampled at a clock edge is reported after that edge. `err_mask_o` equals the received word XOR the expected word, and `err_cnt_o` equals the number of ones in `err_mask_o`.
- R5: When not locked, the expected word is predicted from received bits. A clean stream at any bit offset, in any mode, gives an all-zero mask from the first word after a resynchronize word.
- R6: `lock_o` rises at the edge that samples the GOOD_RUN-th consecutive good word. A good word has a zero mask and is not all zero.
- R7: An errored word while not locked restarts the good-word count from zero.
- R8: An all-zero received word never counts as good, so an all-zero stream never locks.
- R9: When locked, the expected sequence advances from internal state only. A word with flipped bits reports exactly those bits, and the next clean word reports a zero mask.
- R10: Windows of LOSS_WIN words follow one another from the lock edge. Lock drops at the edge that samples the LOSS_THR-th errored word within one window. Fewer errored words in each window keep the lock.
- R11: A word sampled with `resync_i` high clears lock at that edge and restarts the good-word count. It also reseeds the history from that word, so a new stream locks after GOOD_RUN further good words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one received word per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Sequence select: 0 = 7-bit, 1 = 23-bit, 2 or 3 = 31-bit |
| resync_i | input | 1 | Return to acquisition and reseed from the current word |
| rx_word_i | input | WORD_W | Received parallel word, bit 0 earliest |
| lock_o | output | 1 | Checker is running on internal seeding |
| err_mask_o | output | WORD_W | Received XOR expected for the last sampled word |
| err_cnt_o | output | $clog2(WORD_W+1) | Count of ones in `err_mask_o` |

## Verification
The assertions assume that `mode_i` changes only together with `resync_i` or reset, so that history from one polynomial is never judged under another. The stimulus keeps to this: the bench switches mode only under reset and opens every acquisition with a resynchronize word, so the history is filled with true stream bits before the good-word count starts. The loss-of-lock assertion also assumes that windows are counted from the lock edge. The bench therefore places its errored words relative to that edge, filling one window up to the threshold and the next one past it.

// File: rtl/prbs_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the per-bit feedback tap for the sequence engines.
// Assumes the history register holds the most recent bit at index 0.
package prbs_pkg;

    localparam int HIST_W = 31;

    typedef enum logic [1:0] {
        PAT_7  = 2'd0,
        PAT_23 = 2'd1,
        PAT_31 = 2'd2,
        PAT_31B = 2'd3
    } pat_e;

    // Next serial bit from a history where h[k] is the bit k+1 positions back
    function automatic logic tap_bit(input logic [HIST_W-1:0] h, input logic [1:0] m);
        logic b;
        case (pat_e'(m))
            PAT_7:   b = h[6]  ^ h[5];
            PAT_23:  b = h[22] ^ h[17];
            default: b = h[30] ^ h[27];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/prbs_step.sv
`timescale 1ns/1ps
// prbs_step: combinational unrolled advance of the sequence engine by WORD_W bits.
// For each bit it predicts the next sequence bit from the history. It then
// shifts in either that prediction (internal seeding) or the received bit
// (self seeding). Assumes bit 0 of a word is the earliest in time.
module prbs_step
    import prbs_pkg::*;
#(
    parameter int WORD_W = 40
) (
    input  logic [HIST_W-1:0] hist_i,
    input  logic [WORD_W-1:0] rx_i,
    input  logic              use_rx_i,
    input  logic [1:0]        mode_i,
    output logic [WORD_W-1:0] word_o,
    output logic [HIST_W-1:0] hist_o
);

    logic [HIST_W-1:0] h;
    logic              b;

    // Walk the word bit by bit through the feedback recurrence
    always_comb begin
        h = hist_i;
        b = 1'b0;
        word_o = '0;
        for (int i = 0; i < WORD_W; i++) begin
            b = tap_bit(h, mode_i);
            word_o[i] = b;
            h = {h[HIST_W-2:0], (use_rx_i ? rx_i[i] : b)};
        end
        hist_o = h;
    end

endmodule

// File: rtl/prbs_lock_ctrl.sv
`timescale 1ns/1ps
// prbs_lock_ctrl: acquisition and lock state.
// In acquisition it counts consecutive good words and locks on the GOOD_RUN-th.
// While locked it counts errored words in back-to-back windows of LOSS_WIN
// words that start at the lock edge, and unlocks on the LOSS_THR-th.
// Assumes word_ok_i is valid on every cycle.
module prbs_lock_ctrl #(
    parameter int GOOD_RUN = 16,
    parameter int LOSS_WIN = 32,
    parameter int LOSS_THR = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic resync_i,
    input  logic word_ok_i,
    output logic locked_o
);

    localparam int RW = $clog2(GOOD_RUN + 1);
    localparam int WW = $clog2(LOSS_WIN + 1);
    localparam int BW = $clog2(LOSS_THR + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(GOOD_RUN - 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(LOSS_WIN - 1);
    localparam logic [BW-1:0] BAD_MAX  = BW'(LOSS_THR);

    logic          locked_q;
    logic [RW-1:0] run_q;
    logic [WW-1:0] win_q;
    logic [BW-1:0] bad_q;
    logic [BW-1:0] bad_nxt;

    // Errored-word count including the current word
    always_comb bad_nxt = bad_q + (word_ok_i ? BW'(0) : BW'(1));

    // Acquisition run counter, loss window and lock flag
    always_ff @(posedge clk) begin
        if (!rst_n || resync_i) begin
            locked_q <= 1'b0;
            run_q    <= '0;
            win_q    <= '0;
            bad_q    <= '0;
        end else if (!locked_q) begin
            win_q <= '0;
            bad_q <= '0;
            if (!word_ok_i) begin
                run_q <= '0;
            end else if (run_q == RUN_LAST) begin
                locked_q <= 1'b1;
                run_q    <= '0;
            end else begin
                run_q <= run_q + RW'(1);
            end
        end else begin
            run_q <= '0;
            if (bad_nxt >= BAD_MAX) begin
                locked_q <= 1'b0;
                win_q    <= '0;
                bad_q    <= '0;
            end else if (win_q == WIN_LAST) begin
                win_q <= '0;
                bad_q <= '0;
            end else begin
                win_q <= win_q + WW'(1);
                bad_q <= bad_nxt;
            end
        end
    end

    assign locked_o = locked_q;

    // R6: the run counter never reaches GOOD_RUN
    a_r6_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < RW'(GOOD_RUN));

    // R10: the errored-word count never reaches the threshold while held
    a_r10_bad_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bad_q < BAD_MAX);

    // R10: the threshold-th errored word in a window unlocks
    a_r10_loss_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && !word_ok_i && bad_q == BW'(LOSS_THR - 1)) |=> !locked_q);

    // R7: an errored word in acquisition restarts the run
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_q && !word_ok_i) |=> (run_q == '0 && !locked_q));

endmodule

// File: rtl/prbs_gen.sv
`timescale 1ns/1ps
// prbs_gen: transmit-side generator of WORD_W sequence bits per clock.
// The history resets to all ones, and the output holds all ones during reset.
// Assumes mode_i changes only while reset is held.
module prbs_gen
    import prbs_pkg::*;
#(
    parameter int WORD_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    output logic [WORD_W-1:0] gen_word_o
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_nxt;
    logic [WORD_W-1:0] word_nxt;

    prbs_step #(.WORD_W(WORD_W)) u_step (
        .hist_i   (hist_q),
        .rx_i     ('0),
        .use_rx_i (1'b0),
        .mode_i   (mode_i),
        .word_o   (word_nxt),
        .hist_o   (hist_nxt)
    );

    // Advance the free-running history and register the output word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q     <= '1;
            gen_word_o <= '1;
        end else begin
            hist_q     <= hist_nxt;
            gen_word_o <= word_nxt;
        end
    end

    // R2: a maximal-length sequence never yields an all-zero word
    a_r2_gen_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        gen_word_o != '0);

endmodule

// File: rtl/prbs_checker.sv
`timescale 1ns/1ps
// prbs_checker: self-seeding sequence error checker (top).
// Before lock, the expected word is predicted from received bits. After lock,
// it comes from internal state only. Outputs are registered one edge after
// the word is sampled. Assumes one word per clock and that mode_i changes
// only together with resync_i or reset.
module prbs_checker
    import prbs_pkg::*;
#(
    parameter int WORD_W   = 40,
    parameter int GOOD_RUN = 16,
    parameter int LOSS_WIN = 32,
    parameter int LOSS_THR = 8,
    localparam int CNT_W   = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              resync_i,
    input  logic [WORD_W-1:0] rx_word_i,
    output logic              lock_o,
    output logic [WORD_W-1:0] err_mask_o,
    output logic [CNT_W-1:0]  err_cnt_o
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_nxt;
    logic [WORD_W-1:0] exp_word;
    logic [WORD_W-1:0] mask;
    logic [CNT_W-1:0]  cnt;
    logic              seed_rx;
    logic              word_ok;

    // Seed from received data outside lock or on a resync word
    assign seed_rx = !lock_o || resync_i;

    prbs_step #(.WORD_W(WORD_W)) u_step (
        .hist_i   (hist_q),
        .rx_i     (rx_word_i),
        .use_rx_i (seed_rx),
        .mode_i   (mode_i),
        .word_o   (exp_word),
        .hist_o   (hist_nxt)
    );

    // Compare the received word with the expected word and count differing bits
    always_comb begin
        mask = rx_word_i ^ exp_word;
        cnt  = '0;
        for (int i = 0; i < WORD_W; i++) begin
            cnt = cnt + CNT_W'(mask[i]);
        end
    end

    // A good word is clean; before lock it must also be a non-zero seed
    assign word_ok = (mask == '0) && (lock_o || (rx_word_i != '0));

    prbs_lock_ctrl #(
        .GOOD_RUN (GOOD_RUN),
        .LOSS_WIN (LOSS_WIN),
        .LOSS_THR (LOSS_THR)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .resync_i  (resync_i),
        .word_ok_i (word_ok),
        .locked_o  (lock_o)
    );

    // History update and registered error report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q     <= '0;
            err_mask_o <= '0;
            err_cnt_o  <= '0;
        end else begin
            hist_q     <= hist_nxt;
            err_mask_o <= mask;
            err_cnt_o  <= cnt;
        end
    end

    // R4: the bit count agrees with the reported mask
    a_r4_cnt_mask: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt_o == CNT_W'($countones(err_mask_o)));

    // R6: lock is only gained on a clean word
    a_r6_lock_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> err_cnt_o == '0);

    // R8: an all-zero word never brings lock
    a_r8_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_o && rx_word_i == '0) |=> !lock_o);

    // R11: a resync word always clears lock
    a_r11_resync: assert property (@(posedge clk) disable iff (!rst_n)
        resync_i |=> !lock_o);

endmodule

// File: tb/prbs_checker_bench.sv
`timescale 1ns/1ps
module prbs_checker_bench;

    localparam int W   = 40;
    localparam int GR  = 16;
    localparam int LW  = 32;
    localparam int LT  = 8;
    localparam int SQN = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        resync = 1'b0;
    logic [W-1:0] rx = '0;
    logic        lock;
    logic [W-1:0] emask;
    logic [5:0]  ecnt;
    logic [W-1:0] gword;

    int checks = 0;
    int errors = 0;
    bit sq [0:SQN-1];

    always #2.5 clk = ~clk;

    prbs_checker #(.WORD_W(W), .GOOD_RUN(GR), .LOSS_WIN(LW), .LOSS_THR(LT)) u_prbs_checker (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .resync_i(resync),
        .rx_word_i(rx), .lock_o(lock), .err_mask_o(emask), .err_cnt_o(ecnt)
    );

    prbs_gen #(.WORD_W(W)) u_gen (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .gen_word_o(gword)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference stream: 31 leading ones, then the recurrence from R1
    task automatic build(input int m);
        int l, t;
        l = (m == 0) ? 7 : (m == 1) ? 23 : 31;
        t = (m == 0) ? 6 : (m == 1) ? 18 : 28;
        for (int n = 0; n < SQN; n++)
            sq[n] = (n < 31) ? 1'b1 : (sq[n-l] ^ sq[n-t]);
    endtask

    function automatic logic [W-1:0] sw(input int off, input int k);
        logic [W-1:0] w;
        for (int i = 0; i < W; i++) w[i] = sq[31 + off + W*k + i];
        return w;
    endfunction

    task automatic step(input logic [W-1:0] w, input logic rs);
        @(negedge clk);
        rx = w;
        resync = rs;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input int m);
        @(negedge clk);
        rst_n = 1'b0;
        mode = 2'(m);
        rx = '0;
        resync = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R3 reset lock", 64'(lock), 64'd0);
        check("R3 reset mask", 64'(emask), 64'd0);
        check("R3 reset cnt", 64'(ecnt), 64'd0);
        check("R2 gen reset", 64'(gword), 64'(40'hFF_FFFF_FFFF));
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Resync word then GR clean words; checks R5 and R6 timing
    task automatic acquire(input int off, inout int k);
        step(sw(off, k), 1'b1);
        check("R11 resync clears lock", 64'(lock), 64'd0);
        k++;
        for (int j = 1; j <= GR; j++) begin
            step(sw(off, k), 1'b0);
            k++;
            check("R5 acquire mask", 64'(emask), 64'd0);
            if (j >= GR - 1) check("R6 lock timing", 64'(lock), 64'(j == GR));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        logic [W-1:0] w;
        // Generator against the reference recurrence, all modes (R1, R2)
        for (int m = 0; m < 3; m++) begin
            build(m);
            do_reset(m);
            @(posedge clk);
            #1;
            for (int g = 0; g < 64; g++) begin
                check("R1 R2 gen word", 64'(gword), 64'(sw(0, g)));
                @(posedge clk);
                #1;
            end
        end

        // Lock at several offsets, locked error reporting and loss window (R9, R10)
        for (int m = 0; m < 3; m++) begin
            build(m);
            do_reset(m);
            for (int oi = 0; oi < 2; oi++) begin
                int off;
                off = (oi == 0) ? 13 * m : 27;
                k = 0;
                acquire(off, k);
                for (int p = 0; p < 2 * LW; p++) begin
                    int b;
                    bit bad;
                    b = (p * 7) % W;
                    bad = (p < LT - 1) || (p >= LW && p < LW + LT);
                    if (p > LW + LT - 1) break;
                    w = sw(off, k);
                    if (bad) w[b] = ~w[b];
                    step(w, 1'b0);
                    k++;
                    if (p < LW + LT - 1) begin
                        check("R9 locked mask", 64'(emask), bad ? (64'd1 << b) : 64'd0);
                        check("R4 locked cnt", 64'(ecnt), bad ? 64'd1 : 64'd0);
                        check("R10 below threshold keeps lock", 64'(lock), 64'd1);
                    end else begin
                        check("R10 threshold drops lock", 64'(lock), 64'd0);
                    end
                end
            end
        end

        // Multi-bit error while locked, then clean word (R4, R9)
        k = 0;
        acquire(5, k);
        w = sw(5, k);
        w[0] = ~w[0]; w[9] = ~w[9]; w[39] = ~w[39];
        step(w, 1'b0); k++;
        check("R4 multi mask", 64'(emask), 64'h80_0000_0201);
        check("R4 multi cnt", 64'(ecnt), 64'd3);
        step(sw(5, k), 1'b0); k++;
        check("R9 next word clean", 64'(emask), 64'd0);

        // Resync while locked to a new offset (R11)
        k = 0;
        acquire(21, k);

        // Error during acquisition restarts the run (R7)
        k = 0;
        step(sw(3, k), 1'b1); k++;
        for (int j = 1; j <= 10; j++) begin
            step(sw(3, k), 1'b0); k++;
        end
        w = sw(3, k); w[39] = ~w[39];
        step(w, 1'b0); k++;
        check("R7 acquire error mask", 64'(emask), 64'h80_0000_0000);
        step(sw(3, k), 1'b0); k++;
        check("R7 echo error seen", 64'(emask != 0), 64'd1);
        for (int j = 1; j <= GR; j++) begin
            step(sw(3, k), 1'b0); k++;
            if (j == 5) check("R7 no lock from old run", 64'(lock), 64'd0);
            if (j >= GR - 1) check("R7 lock after full new run", 64'(lock), 64'(j == GR));
        end

        // All-zero stream never locks (R8)
        step('0, 1'b1);
        for (int j = 0; j < 2 * GR; j++) step('0, 1'b0);
        check("R8 zero stream mask", 64'(emask), 64'd0);
        check("R8 zero stream no lock", 64'(lock), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule